// File: doc/BRIEF.md
# Serial Line Coding Unit

This unit sits between a bit-level serial engine and the line drivers. It converts a plain bit stream to a line waveform and back again. The coding is chosen at run time: plain level (NRZ), transition-for-zero (NRZI) or two-level-per-cell Manchester. The same selection applies to both directions.

The transmit side is paced by a half-period strobe of the transmit clock. Each strobe toggles the transmit clock output. A control input picks which clock edge launches a new bit: the rising edge or the falling edge. The other edge is the cell centre, where Manchester coding inverts the line.

The receive side synchronises the incoming line and runs a 4-bit phase counter on a 16x oversampling enable. The counter is steered by the line transitions it sees. From that timing the unit issues one decoded bit per cell with a valid strobe, and it raises an asynchronous flag whenever it is not locked. When the flag is raised, the loop resynchronises on its own without outside help.

Top module: `line_codec`

## Requirements
- R1: While rst_ni is low, tx_line_o and tx_clk_o are 0, rx_valid_o is 0 and rx_async_o is 1.
- R2: Each cycle with tx_half_i high toggles tx_clk_o one cycle later. In cycles without tx_half_i, neither tx_clk_o nor tx_line_o changes.
- R3: With tx_inv_i = 0, a bit is launched on the strobe that drives tx_clk_o from 0 to 1. With tx_inv_i = 1, it is launched on the strobe that drives tx_clk_o from 1 to 0. The other strobe is the cell centre.
- R4: mode_i = 2'b00 (NRZ, and also 2'b11): on a launch strobe tx_line_o takes the value of tx_bit_i.
- R5: mode_i = 2'b01 (NRZI): on a launch strobe, a 0 bit inverts tx_line_o and a 1 bit leaves it unchanged.
- R6: mode_i = 2'b10 (Manchester): on a launch strobe tx_line_o takes tx_bit_i, and on the centre strobe it inverts.
- R7: rx_async_o clears only after the loop has acquired the line and then seen four consecutive transitions within two samples of the expected phase. Three cells of preamble are not enough to clear it.
- R8: In Manchester mode the receiver issues one rx_valid_o pulse per 16-sample cell. rx_bit_o is the inverse of the line level sampled three quarters of the way through the cell, so the recovered stream matches the sent bits.
- R9: In NRZ mode rx_bit_o is the line level at mid-cell. In NRZI mode rx_bit_o is 1 when that level equals the previous cell's level and 0 when it differs.
- R10: In Manchester mode, once locked, two consecutive recovered cells without a mid-cell transition set rx_async_o to 1. One missing cell does not.
- R11: After a loss of sync, a new preamble relocks the loop and correct decoding resumes with no other action.
- R12: A transition more than one sample early or late moves the phase counter one step toward the expected phase. Manchester cells of 15 or 17 samples therefore keep lock and decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Coding: 00 NRZ, 01 NRZI, 10 Manchester, 11 NRZ |
| tx_inv_i | input | 1 | 0 launches on the rising transmit clock edge, 1 on the falling edge |
| tx_half_i | input | 1 | Half-period strobe of the transmit clock |
| tx_bit_i | input | 1 | Bit to send, taken on a launch strobe |
| tx_clk_o | output | 1 | Transmit clock |
| tx_line_o | output | 1 | Coded transmit line |
| rx_os_i | input | 1 | 16x oversampling enable |
| rx_line_i | input | 1 | Receive line, asynchronous |
| rx_bit_o | output | 1 | Decoded bit |
| rx_valid_o | output | 1 | One-cycle strobe per recovered cell |
| rx_async_o | output | 1 | 1 while the loop is not locked |

## Verification
- **Transmit:** the outputs are registered, so tx_clk_o and tx_line_o hold their new values from the cycle after a strobe. The bench samples them at the following falling clock edge. It samples once more one idle cycle later to confirm that they held.
- **Receive alignment:** the receive path adds two synchroniser stages, one edge register and one output register. The phase at which the loop settles is not fixed, so decoded bits are not compared by cycle. Instead, the last twelve bits collected while locked must appear as one contiguous run in the sent stream.
- **Lock and loss:** lock is checked after whole preamble cells. Loss is checked 24 cycles after the line goes idle, when one recovered cell can have ended without a transition, and again 48 cycles after. Both points sit at least ten cycles from the cell end at which the flag may change.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    LC_NRZ  = 2'b00,
    LC_NRZI = 2'b01,
    LC_MAN  = 2'b10
  } lc_mode_e;
endpackage

// File: rtl/lc_tx_enc.sv
module lc_tx_enc
  import lc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       inv_i,
  input  logic       half_i,
  input  logic       bit_i,
  output logic       txc_o,
  output logic       line_o
);
  logic txc_q, line_q, line_d, launch;

  // launch edge: 0->1 when not inverted, 1->0 when inverted
  assign launch = half_i && (txc_q == inv_i);

  always_comb begin
    line_d = line_q;
    if (launch) begin
      case (mode_i)
        LC_NRZI: line_d = bit_i ? line_q : ~line_q;
        default: line_d = bit_i;
      endcase
    end else if (half_i && mode_i == LC_MAN) begin
      line_d = ~line_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txc_q  <= 1'b0;
      line_q <= 1'b0;
    end else if (half_i) begin
      txc_q  <= ~txc_q;
      line_q <= line_d;
    end
  end

  assign txc_o  = txc_q;
  assign line_o = line_q;
endmodule

// File: rtl/lc_rx_dpll.sv
module lc_rx_dpll
  import lc_pkg::*;
#(
  parameter int PH_W     = 4,
  parameter int SYNC_N   = 2,
  parameter int LOCK_N   = 4,
  parameter int MISS_N   = 2,
  parameter int TOL      = 1,
  parameter int LOCK_TOL = 2,
  parameter int WIN      = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            os_i,
  input  logic            line_i,
  output logic            lvl_o,
  output logic [PH_W-1:0] phase_o,
  output logic            lock_o
);
  localparam int STK_W = $clog2(LOCK_N + 1);
  localparam int MIS_W = $clog2(MISS_N + 1);
  localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};
  localparam logic [PH_W-1:0] HALF   = PH_W'(2 ** (PH_W - 1));
  localparam logic [PH_W-1:0] TOL_V  = PH_W'(TOL);
  localparam logic [PH_W-1:0] LTOL_V = PH_W'(LOCK_TOL);
  localparam logic [PH_W-1:0] WIN_V  = PH_W'(WIN);
  localparam logic [STK_W-1:0] STK_LAST = STK_W'(LOCK_N - 1);
  localparam logic [MIS_W-1:0] MIS_LAST = MIS_W'(MISS_N - 1);

  logic [SYNC_N-1:0] sync_q;
  logic              lvl, lvl_q;
  logic [PH_W-1:0]   ph_q, ph_d, target, err, mag;
  logic              lock_q, lock_d, seen_q, seen_d;
  logic [STK_W-1:0]  stk_q, stk_d;
  logic [MIS_W-1:0]  mis_q, mis_d;
  logic              is_man, edge_w, in_win, near, late, jump, nudge, cell_end;

  assign lvl      = sync_q[SYNC_N-1];
  assign is_man   = (mode_i == LC_MAN);
  assign target   = is_man ? HALF : '0;
  assign err      = ph_q - target;
  assign mag      = err[PH_W-1] ? (~err + 1'b1) : err;
  assign late     = !err[PH_W-1];
  assign edge_w   = os_i && (lvl != lvl_q);
  assign in_win   = !is_man || (mag <= WIN_V);
  assign near     = (mag <= LTOL_V);
  assign jump     = edge_w && !lock_q && !near;
  assign nudge    = edge_w && !jump && in_win && (mag > TOL_V);
  assign cell_end = os_i && (ph_q == PH_MAX);

  always_comb begin
    ph_d   = ph_q;
    lock_d = lock_q;
    seen_d = seen_q;
    stk_d  = stk_q;
    mis_d  = mis_q;
    if (os_i) begin
      ph_d = ph_q + 1'b1;
      if (jump)       ph_d = target + 1'b1;
      else if (nudge) ph_d = late ? ph_q : ph_q + PH_W'(2);
      if (cell_end) begin
        seen_d = 1'b0;
        if (is_man && lock_q) begin
          if (seen_q) mis_d = '0;
          else if (mis_q == MIS_LAST) begin
            lock_d = 1'b0;
            mis_d  = '0;
            stk_d  = '0;
          end else mis_d = mis_q + 1'b1;
        end
      end
      if (edge_w && (in_win || jump)) seen_d = 1'b1;
      if (jump) stk_d = '0;
      else if (edge_w && near && !lock_q) begin
        if (stk_q == STK_LAST) begin
          lock_d = 1'b1;
          stk_d  = '0;
          mis_d  = '0;
        end else stk_d = stk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      ph_q   <= '0;
      lock_q <= 1'b0;
      seen_q <= 1'b0;
      stk_q  <= '0;
      mis_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], line_i};
      if (os_i) lvl_q <= lvl;
      ph_q   <= ph_d;
      lock_q <= lock_d;
      seen_q <= seen_d;
      stk_q  <= stk_d;
      mis_q  <= mis_d;
    end
  end

  assign lvl_o   = lvl;
  assign phase_o = ph_q;
  assign lock_o  = lock_q;
endmodule

// File: rtl/lc_rx_dec.sv
module lc_rx_dec
  import lc_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            os_i,
  input  logic            lvl_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            bit_o,
  output logic            valid_o
);
  localparam logic [PH_W-1:0] SP_MID = PH_W'(2 ** (PH_W - 1));
  localparam logic [PH_W-1:0] SP_Q3  = PH_W'(3 * 2 ** (PH_W - 2));

  logic [PH_W-1:0] sp;
  logic take, bit_d, bit_q, valid_q, prev_q;

  assign sp   = (mode_i == LC_MAN) ? SP_Q3 : SP_MID;
  assign take = os_i && (phase_i == sp);

  always_comb begin
    case (mode_i)
      LC_MAN:  bit_d = ~lvl_i;
      LC_NRZI: bit_d = ~(lvl_i ^ prev_q);
      default: bit_d = lvl_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) begin
        bit_q  <= bit_d;
        prev_q <= lvl_i;
      end
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/line_codec.sv
module line_codec
  import lc_pkg::*;
#(
  parameter int PH_W     = 4,
  parameter int SYNC_N   = 2,
  parameter int LOCK_N   = 4,
  parameter int MISS_N   = 2,
  parameter int TOL      = 1,
  parameter int LOCK_TOL = 2,
  parameter int WIN      = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tx_inv_i,
  input  logic       tx_half_i,
  input  logic       tx_bit_i,
  output logic       tx_clk_o,
  output logic       tx_line_o,
  input  logic       rx_os_i,
  input  logic       rx_line_i,
  output logic       rx_bit_o,
  output logic       rx_valid_o,
  output logic       rx_async_o
);
  logic            lvl, lock;
  logic [PH_W-1:0] phase;

  lc_tx_enc u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .inv_i  (tx_inv_i),
    .half_i (tx_half_i),
    .bit_i  (tx_bit_i),
    .txc_o  (tx_clk_o),
    .line_o (tx_line_o)
  );

  lc_rx_dpll #(
    .PH_W(PH_W), .SYNC_N(SYNC_N), .LOCK_N(LOCK_N), .MISS_N(MISS_N),
    .TOL(TOL), .LOCK_TOL(LOCK_TOL), .WIN(WIN)
  ) u_dpll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .os_i    (rx_os_i),
    .line_i  (rx_line_i),
    .lvl_o   (lvl),
    .phase_o (phase),
    .lock_o  (lock)
  );

  lc_rx_dec #(.PH_W(PH_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .os_i    (rx_os_i),
    .lvl_i   (lvl),
    .phase_i (phase),
    .bit_o   (rx_bit_o),
    .valid_o (rx_valid_o)
  );

  assign rx_async_o = ~lock;
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       tx_inv_i,
  input logic       tx_half_i,
  input logic       tx_bit_i,
  input logic       tx_clk_o,
  input logic       tx_line_o,
  input logic       rx_valid_o,
  input logic       rx_async_o
);
  AST_TXC_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_half_i |=> tx_clk_o != $past(tx_clk_o)); // R2

  AST_TX_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_half_i |=> $stable(tx_line_o) && $stable(tx_clk_o)); // R2

  AST_NRZ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_half_i && tx_clk_o == tx_inv_i && mode_i == 2'b00)
      |=> tx_line_o == $past(tx_bit_i)); // R4

  AST_NRZI_ONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_half_i && tx_clk_o == tx_inv_i && mode_i == 2'b01 && tx_bit_i)
      |=> $stable(tx_line_o)); // R5

  AST_MAN_MID_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_half_i && tx_clk_o != tx_inv_i && mode_i == 2'b10)
      |=> tx_line_o != $past(tx_line_o)); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R8

  AST_LOSS_MAN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_async_o) |-> $past(mode_i) == 2'b10); // R10
endmodule

bind line_codec lc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .tx_inv_i   (tx_inv_i),
  .tx_half_i  (tx_half_i),
  .tx_bit_i   (tx_bit_i),
  .tx_clk_o   (tx_clk_o),
  .tx_line_o  (tx_line_o),
  .rx_valid_o (rx_valid_o),
  .rx_async_o (rx_async_o)
);

// File: tb/tb_line_codec.sv
module tb_line_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tx_inv = 1'b0, tx_half = 1'b0, tx_bit = 1'b0;
  logic       rx_os = 1'b1, rx_line = 1'b0;
  logic       tx_clk_o, tx_line_o, rx_bit_o, rx_valid_o, rx_async_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic txc_e, line_e;
  int sent [0:255];
  int got  [0:255];
  int ns = 0, ng = 0, vcount = 0;

  always #4 clk = ~clk;

  line_codec dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tx_inv_i(tx_inv),
    .tx_half_i(tx_half), .tx_bit_i(tx_bit), .tx_clk_o(tx_clk_o),
    .tx_line_o(tx_line_o), .rx_os_i(rx_os), .rx_line_i(rx_line),
    .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o), .rx_async_o(rx_async_o)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid_o) begin
      vcount++;
      if (!rx_async_o && ng < 256) begin
        got[ng] = int'(rx_bit_o);
        ng++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic inv);
    rst_n = 1'b0; tx_half = 1'b0; tx_bit = 1'b0; rx_line = 1'b0;
    mode = m; tx_inv = inv;
    txc_e = 1'b0; line_e = 1'b0; ns = 0; ng = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // transmit model built from R2..R6
  task automatic half(input logic b, input string req);
    tx_bit = b;
    tx_half = 1'b1;
    if (txc_e == tx_inv) begin
      if (mode == 2'b01) begin
        if (!b) line_e = ~line_e;
      end else line_e = b;
    end else if (mode == 2'b10) line_e = ~line_e;
    txc_e = ~txc_e;
    @(negedge clk);
    tx_half = 1'b0;
    chk({req, " clk"}, int'(tx_clk_o), int'(txc_e));
    chk({req, " line"}, int'(tx_line_o), int'(line_e));
    @(negedge clk);
    chk("R2 hold", int'(tx_line_o), int'(line_e));
  endtask

  task automatic test_tx(input logic [1:0] m, input logic inv, input string req);
    logic [15:0] pat = 16'hB38E;
    do_reset(m, inv);
    if (txc_e != tx_inv) half(1'b1, req);
    for (int i = 0; i < 16; i++) begin
      half(pat[i], req);
      half(pat[i], req);
    end
  endtask

  task automatic man_cell(input int b, input int len);
    rx_line = b[0];
    repeat (len / 2) @(negedge clk);
    rx_line = ~b[0];
    repeat (len - len / 2) @(negedge clk);
    sent[ns] = b; ns++;
  endtask

  task automatic nrz_cell(input logic lv, input int b);
    rx_line = lv;
    repeat (16) @(negedge clk);
    sent[ns] = b; ns++;
  endtask

  function automatic int tail_ok(input int k);
    if (ng < k) return 0;
    for (int s = 0; s + k <= ns; s++) begin
      int ok = 1;
      for (int j = 0; j < k; j++) if (got[ng - k + j] != sent[s + j]) ok = 0;
      if (ok == 1) return 1;
    end
    return 0;
  endfunction

  localparam logic [19:0] PAY = 20'hC5A3B;

  task automatic man_stream(input int len, input int pre);
    for (int i = 0; i < pre; i++) man_cell(i % 2 == 0 ? 1 : 0, len);
    for (int i = 0; i < 20; i++) man_cell(int'(PAY[i]), len);
    man_cell(1, len);
    man_cell(1, len);
  endtask

  task automatic test_rx_man();
    int v0;
    do_reset(2'b10, 1'b0);
    chk("R1 async", int'(rx_async_o), 1);
    for (int i = 0; i < 3; i++) man_cell(i % 2 == 0 ? 1 : 0, 16);
    chk("R7 not yet locked", int'(rx_async_o), 1);
    for (int i = 3; i < 12; i++) man_cell(i % 2 == 0 ? 1 : 0, 16);
    chk("R7 locked", int'(rx_async_o), 0);
    for (int i = 0; i < 20; i++) man_cell(int'(PAY[i]), 16);
    man_cell(1, 16);
    man_cell(1, 16);
    chk("R8 data", tail_ok(12), 1);
    v0 = vcount;
    for (int i = 0; i < 10; i++) man_cell(i % 2, 16);
    chk("R8 one valid per cell", vcount - v0, 10);
  endtask

  task automatic test_loss_resync();
    // line idles at its last level: no mid-cell transitions
    repeat (24) @(negedge clk);
    chk("R10 one missing cell", int'(rx_async_o), 0);
    repeat (24) @(negedge clk);
    chk("R10 two missing cells", int'(rx_async_o), 1);
    ns = 0; ng = 0;
    man_stream(16, 16);
    chk("R11 relocked", int'(rx_async_o), 0);
    chk("R11 data", tail_ok(12), 1);
  endtask

  task automatic test_rx_nrz();
    do_reset(2'b00, 1'b0);
    for (int i = 0; i < 16; i++) nrz_cell(i % 2 == 0, i % 2 == 0 ? 1 : 0);
    for (int i = 0; i < 20; i++) nrz_cell(PAY[i], int'(PAY[i]));
    nrz_cell(1'b0, 0);
    nrz_cell(1'b0, 0);
    chk("R9 nrz lock", int'(rx_async_o), 0);
    chk("R9 nrz data", tail_ok(12), 1);
  endtask

  task automatic test_rx_nrzi();
    logic lv = 1'b0;
    do_reset(2'b01, 1'b0);
    for (int i = 0; i < 16; i++) begin
      lv = ~lv;
      nrz_cell(lv, 0);
    end
    for (int i = 0; i < 20; i++) begin
      if (!PAY[i]) lv = ~lv;
      nrz_cell(lv, int'(PAY[i]));
    end
    nrz_cell(lv, 1);
    nrz_cell(lv, 1);
    chk("R9 nrzi lock", int'(rx_async_o), 0);
    chk("R9 nrzi data", tail_ok(12), 1);
  endtask

  task automatic test_track(input int len);
    do_reset(2'b10, 1'b0);
    man_stream(len, 16);
    chk($sformatf("R12 lock len %0d", len), int'(rx_async_o), 0);
    chk($sformatf("R12 data len %0d", len), tail_ok(12), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 tx_line", int'(tx_line_o), 0);
    chk("R1 tx_clk", int'(tx_clk_o), 0);
    chk("R1 valid", int'(rx_valid_o), 0);
    chk("R1 async", int'(rx_async_o), 1);
    test_tx(2'b00, 1'b0, "R4");
    test_tx(2'b01, 1'b0, "R5");
    test_tx(2'b10, 1'b0, "R6");
    test_tx(2'b00, 1'b1, "R3 nrz");
    test_tx(2'b10, 1'b1, "R3 man");
    test_rx_man();
    test_loss_resync();
    test_rx_nrz();
    test_rx_nrzi();
    test_track(17);
    test_track(15);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule